// File: doc/BRIEF.md
# Multi-Mode Macrocell Register Stage

This block is the storage and output-select part of one programmable logic slice. A single state bit can behave as a D, T, JK or SR flip-flop, or as a level-transparent latch. The mode, the clock source, the clock enable, the asynchronous clear and set sources, the data source, the output path and the output-enable source are each picked by static configuration inputs. The slice drives three results: the pad data, the pad output enable and a feedback bit for the routing fabric. The state bit can also be hidden from the pad, so that the pad carries the combinational value while the register still feeds back.

The block runs on a fast system clock `clk`. The "clock" sources (`clk_pin`, `pt_clk`) are level signals that the block samples on every system edge. A rising edge of the selected source is a cycle in which the source is sampled high after it was sampled low in the previous cycle. The state bit changes at that same system edge and uses the inputs present then. Clear and set are level controls. While one is asserted, it forces the state at the next system edge, whether or not the selected clock moves. `por_n` is the power-up reset and clears the whole block asynchronously.

Top module: `macrocell_reg`

## Requirements
- R1: While `por_n` is low, the state bit and the stored previous clock level are 0, so a registered pad reads 0.
- R2: With `cfg_mode`=0 (D), a rising edge of the selected clock loads the data value. In cycles without such an edge, the state holds.
- R3: `cfg_clk_sel`=0 selects `clk_pin` and `cfg_clk_sel`=1 selects `pt_clk`. Edges on the source that is not selected have no effect.
- R4: With `cfg_clk_sel`=0 and `cfg_ce_en`=1, edges that arrive while `pt_ce` is low are ignored. With `cfg_clk_sel`=1, `pt_ce` has no effect.
- R5: With `cfg_mode`=1 (T), an edge inverts the state when the data value is 1 and holds it when the data value is 0.
- R6: With `cfg_mode`=2 (JK), J=`xor_val` and K=`pt_data`. On an edge, JK=00 holds, 01 clears, 10 sets and 11 toggles.
- R7: With `cfg_mode`=3 (SR), S=`xor_val` and R=`pt_data`. On an edge, 00 holds, 01 clears and 10 sets. SR=11 holds.
- R8: With `cfg_mode`=4 (latch), the state follows the data value in every cycle in which the selected clock is high, and holds while it is low. Codes 5 to 7 act as D.
- R9: `cfg_rst_sel` picks the clear source: 0 none, 1 `gclr_n` low (active low), 2 `pt_rst` high, 3 either. An active clear zeroes the state at the next system edge without a clock edge.
- R10: With `cfg_pre_en`=1, `pt_pre` high sets the state at the next system edge. With `cfg_pre_en`=0, `pt_pre` is ignored. When clear and set are both active, the state becomes 0.
- R11: In D, T and latch modes, the data value is `xor_val` when `cfg_data_sel`=0 and `pt_data` when `cfg_data_sel`=1.
- R12: With `cfg_out_reg`=1, both the pad and the feedback carry the state. With `cfg_out_reg`=0, the pad carries `xor_val` and the feedback carries the state if `cfg_fb_sel`=1, or `xor_val` if `cfg_fb_sel`=0.
- R13: `cfg_oe_sel` sets `pad_oe`: 0 off, 1 on, 2+i follows the inverse of `oe_pin_n[i]` (active low, i below NUM_GOE), 2+NUM_GOE follows `pt_oe`. Any other code means off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every source |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| cfg_mode | input | 3 | Storage mode: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| cfg_clk_sel | input | 1 | Clock source: 0 global pin, 1 product term |
| cfg_ce_en | input | 1 | Enables the clock-enable term (global clock only) |
| cfg_rst_sel | input | 2 | Clear source: 0 none, 1 pin, 2 term, 3 both |
| cfg_pre_en | input | 1 | Enables the set term |
| cfg_data_sel | input | 1 | Data source: 0 XOR path, 1 separate term |
| cfg_out_reg | input | 1 | Pad carries state (1) or combinational value (0) |
| cfg_fb_sel | input | 1 | With a combinational pad: feedback is state (1) or combinational value (0) |
| cfg_oe_sel | input | OE_SEL_W | Output-enable source code |
| clk_pin | input | 1 | Global clock level |
| pt_clk | input | 1 | Product-term clock level |
| pt_ce | input | 1 | Clock-enable term, active high |
| gclr_n | input | 1 | Global clear, active low |
| pt_rst | input | 1 | Clear term, active high |
| pt_pre | input | 1 | Set term, active high |
| oe_pin_n | input | NUM_GOE | Global output-enable pins, active low |
| pt_oe | input | 1 | Output-enable term |
| xor_val | input | 1 | Combinational XOR-path value (also J / S) |
| pt_data | input | 1 | Separate data term (also K / R) |
| pad_data | output | 1 | Data toward the pad |
| pad_oe | output | 1 | Pad output enable |
| fb_out | output | 1 | Feedback to the routing fabric |

## Verification
The bench builds the block with NUM_GOE=2, which gives five meaningful output-enable codes. At this size the bench can sweep every code against every pin and term combination. The single state bit and two input bits let the bench cover every mode against both data sources, both starting states and all four input pairs, so each line of the JK and SR tables is checked from both states. The directed tests then cover clock selection, the clock enable, each clear source, the clear-over-set priority and the latch's transparent and holding phases.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
    localparam logic [2:0] MODE_D     = 3'd0;
    localparam logic [2:0] MODE_T     = 3'd1;
    localparam logic [2:0] MODE_JK    = 3'd2;
    localparam logic [2:0] MODE_SR    = 3'd3;
    localparam logic [2:0] MODE_LATCH = 3'd4;

    localparam logic [1:0] RST_NONE = 2'd0;
    localparam logic [1:0] RST_PIN  = 2'd1;
    localparam logic [1:0] RST_TERM = 2'd2;
    localparam logic [1:0] RST_BOTH = 2'd3;

    typedef struct packed {
        logic q;
        logic mclk_prev;
    } cell_state_t;
endpackage

// File: rtl/mc_clk_sel.sv
`timescale 1ns/1ps
module mc_clk_sel (
    input  logic clk_sel,
    input  logic ce_en,
    input  logic clk_pin,
    input  logic pt_clk,
    input  logic pt_ce,
    input  logic mclk_prev,
    output logic mclk,
    output logic fire
);
    logic ce_ok;

    always_comb begin
        mclk  = clk_sel ? pt_clk : clk_pin;
        // the enable term only gates the global clock
        ce_ok = clk_sel | ~ce_en | pt_ce;
        fire  = mclk & ~mclk_prev & ce_ok;
    end
endmodule

// File: rtl/mc_next_state.sv
`timescale 1ns/1ps
module mc_next_state
    import mc_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       q,
    input  logic       dval,
    input  logic       in_a,
    input  logic       in_b,
    input  logic       fire,
    input  logic       mclk,
    output logic       q_nxt
);
    always_comb begin
        q_nxt = q;
        if (mode == MODE_LATCH) begin
            if (mclk) q_nxt = dval;
        end else if (fire) begin
            case (mode)
                MODE_T:  q_nxt = q ^ dval;
                MODE_JK: begin
                    case ({in_a, in_b})
                        2'b01:   q_nxt = 1'b0;
                        2'b10:   q_nxt = 1'b1;
                        2'b11:   q_nxt = ~q;
                        default: q_nxt = q;
                    endcase
                end
                MODE_SR: begin
                    case ({in_a, in_b})
                        2'b01:   q_nxt = 1'b0;
                        2'b10:   q_nxt = 1'b1;
                        default: q_nxt = q;
                    endcase
                end
                default: q_nxt = dval;
            endcase
        end
    end
endmodule

// File: rtl/mc_out_sel.sv
`timescale 1ns/1ps
module mc_out_sel #(
    parameter  int NUM_GOE  = 2,
    localparam int OE_SEL_W = $clog2(NUM_GOE + 3)
) (
    input  logic                out_reg,
    input  logic                fb_sel,
    input  logic                comb_val,
    input  logic                q,
    input  logic [OE_SEL_W-1:0] oe_sel,
    input  logic [NUM_GOE-1:0]  oe_pin_n,
    input  logic                pt_oe,
    output logic                pad_data,
    output logic                pad_oe,
    output logic                fb_out
);
    always_comb begin
        pad_data = out_reg ? q : comb_val;
        fb_out   = (out_reg | fb_sel) ? q : comb_val;

        pad_oe = 1'b0;
        if (int'(oe_sel) == 1) pad_oe = 1'b1;
        for (int i = 0; i < NUM_GOE; i++) begin
            if (int'(oe_sel) == 2 + i) pad_oe = ~oe_pin_n[i];
        end
        if (int'(oe_sel) == 2 + NUM_GOE) pad_oe = pt_oe;
    end
endmodule

// File: rtl/macrocell_reg.sv
`timescale 1ns/1ps
module macrocell_reg
    import mc_pkg::*;
#(
    parameter  int NUM_GOE  = 2,
    localparam int OE_SEL_W = $clog2(NUM_GOE + 3)
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic [2:0]          cfg_mode,
    input  logic                cfg_clk_sel,
    input  logic                cfg_ce_en,
    input  logic [1:0]          cfg_rst_sel,
    input  logic                cfg_pre_en,
    input  logic                cfg_data_sel,
    input  logic                cfg_out_reg,
    input  logic                cfg_fb_sel,
    input  logic [OE_SEL_W-1:0] cfg_oe_sel,
    input  logic                clk_pin,
    input  logic                pt_clk,
    input  logic                pt_ce,
    input  logic                gclr_n,
    input  logic                pt_rst,
    input  logic                pt_pre,
    input  logic [NUM_GOE-1:0]  oe_pin_n,
    input  logic                pt_oe,
    input  logic                xor_val,
    input  logic                pt_data,
    output logic                pad_data,
    output logic                pad_oe,
    output logic                fb_out
);
    cell_state_t st_d, st_q;
    logic mclk, fire, dval, q_nxt, rst_act, pre_act;

    mc_clk_sel u_clk_sel (
        .clk_sel   (cfg_clk_sel),
        .ce_en     (cfg_ce_en),
        .clk_pin   (clk_pin),
        .pt_clk    (pt_clk),
        .pt_ce     (pt_ce),
        .mclk_prev (st_q.mclk_prev),
        .mclk      (mclk),
        .fire      (fire)
    );

    assign dval = cfg_data_sel ? pt_data : xor_val;

    mc_next_state u_next (
        .mode  (cfg_mode),
        .q     (st_q.q),
        .dval  (dval),
        .in_a  (xor_val),
        .in_b  (pt_data),
        .fire  (fire),
        .mclk  (mclk),
        .q_nxt (q_nxt)
    );

    always_comb begin
        case (cfg_rst_sel)
            RST_PIN:  rst_act = ~gclr_n;
            RST_TERM: rst_act = pt_rst;
            RST_BOTH: rst_act = ~gclr_n | pt_rst;
            default:  rst_act = 1'b0;
        endcase
        pre_act = cfg_pre_en & pt_pre;

        st_d           = st_q;
        st_d.mclk_prev = mclk;
        if (rst_act)      st_d.q = 1'b0;
        else if (pre_act) st_d.q = 1'b1;
        else              st_d.q = q_nxt;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    mc_out_sel #(.NUM_GOE(NUM_GOE)) u_out (
        .out_reg  (cfg_out_reg),
        .fb_sel   (cfg_fb_sel),
        .comb_val (xor_val),
        .q        (st_q.q),
        .oe_sel   (cfg_oe_sel),
        .oe_pin_n (oe_pin_n),
        .pt_oe    (pt_oe),
        .pad_data (pad_data),
        .pad_oe   (pad_oe),
        .fb_out   (fb_out)
    );

    assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!por_n)
        rst_act |=> !st_q.q);

    assert_set_when_no_clear_R10: assert property (@(posedge clk) disable iff (!por_n)
        (pre_act && !rst_act) |=> st_q.q);

    assert_no_edge_holds_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!fire && cfg_mode != MODE_LATCH && !rst_act && !pre_act) |=> $stable(st_q.q));

    assert_ce_low_blocks_R4: assert property (@(posedge clk) disable iff (!por_n)
        (!cfg_clk_sel && cfg_ce_en && !pt_ce && cfg_mode != MODE_LATCH
         && !rst_act && !pre_act) |=> $stable(st_q.q));

    assert_t_zero_holds_R5: assert property (@(posedge clk) disable iff (!por_n)
        (cfg_mode == MODE_T && !dval && !rst_act && !pre_act) |=> $stable(st_q.q));
endmodule

// File: tb/macrocell_reg_bench.sv
`timescale 1ns/1ps
module macrocell_reg_bench;
    localparam int NUM_GOE  = 2;
    localparam int OE_SEL_W = $clog2(NUM_GOE + 3);

    logic clk = 1'b0;
    logic por_n;
    logic [2:0] cfg_mode;
    logic cfg_clk_sel, cfg_ce_en, cfg_pre_en, cfg_data_sel, cfg_out_reg, cfg_fb_sel;
    logic [1:0] cfg_rst_sel;
    logic [OE_SEL_W-1:0] cfg_oe_sel;
    logic clk_pin, pt_clk, pt_ce, gclr_n, pt_rst, pt_pre, pt_oe, xor_val, pt_data;
    logic [NUM_GOE-1:0] oe_pin_n;
    logic pad_data, pad_oe, fb_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    macrocell_reg #(.NUM_GOE(NUM_GOE)) u_macrocell_reg (
        .clk(clk), .por_n(por_n), .cfg_mode(cfg_mode), .cfg_clk_sel(cfg_clk_sel),
        .cfg_ce_en(cfg_ce_en), .cfg_rst_sel(cfg_rst_sel), .cfg_pre_en(cfg_pre_en),
        .cfg_data_sel(cfg_data_sel), .cfg_out_reg(cfg_out_reg), .cfg_fb_sel(cfg_fb_sel),
        .cfg_oe_sel(cfg_oe_sel), .clk_pin(clk_pin), .pt_clk(pt_clk), .pt_ce(pt_ce),
        .gclr_n(gclr_n), .pt_rst(pt_rst), .pt_pre(pt_pre), .oe_pin_n(oe_pin_n),
        .pt_oe(pt_oe), .xor_val(xor_val), .pt_data(pt_data),
        .pad_data(pad_data), .pad_oe(pad_oe), .fb_out(fb_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic force_q(logic v);
        if (v) pt_pre = 1'b1; else pt_rst = 1'b1;
        step();
        pt_pre = 1'b0;
        pt_rst = 1'b0;
    endtask

    task automatic pulse_pin();
        clk_pin = 1'b1; step();
        clk_pin = 1'b0; step();
    endtask

    task automatic pulse_term();
        pt_clk = 1'b1; step();
        pt_clk = 1'b0; step();
    endtask

    function automatic logic model(int m, logic q, logic d, logic a, logic b);
        case (m)
            1:       return q ^ d;
            2:       return (a & b) ? ~q : (a ? 1'b1 : (b ? 1'b0 : q));
            3:       return (a & ~b) ? 1'b1 : ((b & ~a) ? 1'b0 : q);
            default: return d;
        endcase
    endfunction

    initial begin
        por_n = 1'b0;
        cfg_mode = 3'd0; cfg_clk_sel = 0; cfg_ce_en = 0; cfg_rst_sel = 2'd2;
        cfg_pre_en = 1; cfg_data_sel = 0; cfg_out_reg = 1; cfg_fb_sel = 0;
        cfg_oe_sel = '0;
        clk_pin = 0; pt_clk = 0; pt_ce = 0; gclr_n = 1; pt_rst = 0; pt_pre = 0;
        oe_pin_n = '1; pt_oe = 0; xor_val = 0; pt_data = 0;
        #1;
        check("R1 reset pad", pad_data, 1'b0);
        step(); step();
        por_n = 1'b1;
        step();
        check("R1 after release", pad_data, 1'b0);
        force_q(1'b1);
        check("R10 set term without clock", pad_data, 1'b1);
        por_n = 1'b0; #1;
        check("R1 async power-up clear", pad_data, 1'b0);
        step(); por_n = 1'b1; step();

        // near-exhaustive sweep over modes, data source, start state, input pair
        for (int m = 0; m < 4; m++) begin
            for (int ds = 0; ds < 2; ds++) begin
                for (int q0 = 0; q0 < 2; q0++) begin
                    for (int ab = 0; ab < 4; ab++) begin
                        logic a, b, d, exp;
                        string tag;
                        cfg_mode = 3'(m); cfg_data_sel = ds[0];
                        force_q(q0[0]);
                        a = ab[1]; b = ab[0];
                        xor_val = a; pt_data = b;
                        d = ds[0] ? b : a;
                        exp = model(m, q0[0], d, a, b);
                        pulse_pin();
                        case (m)
                            0: tag = "R2 D mode";
                            1: tag = "R5 T mode";
                            2: tag = "R6 JK mode";
                            default: tag = "R7 SR mode";
                        endcase
                        check(tag, pad_data, exp);
                    end
                end
            end
        end
        cfg_mode = 3'd0; xor_val = 0; pt_data = 0;

        // R11 data source select
        cfg_data_sel = 1; force_q(1'b0); xor_val = 1; pt_data = 0; pulse_pin();
        check("R11 term source ignores xor", pad_data, 1'b0);
        cfg_data_sel = 0; pulse_pin();
        check("R11 xor source", pad_data, 1'b1);
        cfg_mode = 3'd5; force_q(1'b0); pulse_pin();
        check("R8 code 5 acts as D", pad_data, 1'b1);
        cfg_mode = 3'd0;

        // R2 no edge: pin held high, data changes
        force_q(1'b0); xor_val = 1; clk_pin = 1; step();
        check("R2 edge loads", pad_data, 1'b1);
        xor_val = 0; step(); step();
        check("R2 level high holds", pad_data, 1'b1);
        clk_pin = 0; step();

        // R3 clock source select
        cfg_clk_sel = 1; force_q(1'b0); xor_val = 1; pulse_pin();
        check("R3 unselected pin ignored", pad_data, 1'b0);
        pulse_term();
        check("R3 term clock loads", pad_data, 1'b1);
        cfg_clk_sel = 0; force_q(1'b0); pulse_term();
        check("R3 unselected term ignored", pad_data, 1'b0);

        // R4 clock enable
        cfg_ce_en = 1; pt_ce = 0; force_q(1'b0); xor_val = 1; pulse_pin();
        check("R4 enable low ignores edge", pad_data, 1'b0);
        pt_ce = 1; pulse_pin();
        check("R4 enable high accepts edge", pad_data, 1'b1);
        pt_ce = 0; cfg_clk_sel = 1; force_q(1'b0); pulse_term();
        check("R4 term clock ignores enable", pad_data, 1'b1);
        cfg_clk_sel = 0; cfg_ce_en = 0;

        // R8 latch
        cfg_mode = 3'd4; force_q(1'b0); clk_pin = 1; xor_val = 1; step();
        check("R8 transparent high", pad_data, 1'b1);
        xor_val = 0; step();
        check("R8 follows while high", pad_data, 1'b0);
        clk_pin = 0; step(); xor_val = 1; step(); step();
        check("R8 holds while low", pad_data, 1'b0);
        cfg_mode = 3'd0; xor_val = 0;

        // R9 clear sources
        cfg_rst_sel = 2'd1; force_q(1'b1); gclr_n = 0; step(); gclr_n = 1;
        check("R9 pin clear active low", pad_data, 1'b0);
        force_q(1'b1); pt_rst = 1; step(); pt_rst = 0;
        check("R9 term ignored when pin selected", pad_data, 1'b1);
        cfg_rst_sel = 2'd0; gclr_n = 0; pt_rst = 1; step(); gclr_n = 1; pt_rst = 0;
        check("R9 no clear source", pad_data, 1'b1);
        cfg_rst_sel = 2'd2; gclr_n = 0; step(); gclr_n = 1;
        check("R9 pin ignored when term selected", pad_data, 1'b1);
        cfg_rst_sel = 2'd3; pt_rst = 1; step(); pt_rst = 0;
        check("R9 both: term clears", pad_data, 1'b0);
        force_q(1'b1); gclr_n = 0; step(); gclr_n = 1;
        check("R9 both: pin clears", pad_data, 1'b0);
        cfg_rst_sel = 2'd2;

        // R10 set enable and priority
        cfg_pre_en = 0; force_q(1'b0); pt_pre = 1; step(); pt_pre = 0;
        check("R10 set disabled", pad_data, 1'b0);
        cfg_pre_en = 1; force_q(1'b1); pt_pre = 1; pt_rst = 1; step(); pt_pre = 0; pt_rst = 0;
        check("R10 clear wins over set", pad_data, 1'b0);

        // R12 output and feedback select
        force_q(1'b0); cfg_out_reg = 0; cfg_fb_sel = 1; xor_val = 1; #1;
        check("R12 comb pad", pad_data, 1'b1);
        check("R12 buried feedback", fb_out, 1'b0);
        cfg_fb_sel = 0; #1;
        check("R12 comb feedback", fb_out, 1'b1);
        cfg_out_reg = 1; #1;
        check("R12 registered pad", pad_data, 1'b0);
        check("R12 registered feedback", fb_out, 1'b0);
        xor_val = 0;

        // R13 output enable sweep
        for (int s = 0; s < 5; s++) begin
            for (int p = 0; p < 4; p++) begin
                for (int t = 0; t < 2; t++) begin
                    logic exp;
                    cfg_oe_sel = OE_SEL_W'(s); oe_pin_n = 2'(p); pt_oe = t[0];
                    #1;
                    case (s)
                        0: exp = 1'b0;
                        1: exp = 1'b1;
                        2: exp = ~p[0];
                        3: exp = ~p[1];
                        default: exp = t[0];
                    endcase
                    check("R13 oe select", pad_oe, exp);
                end
            end
        end
        cfg_oe_sel = OE_SEL_W'(6); #1;
        check("R13 unused code off", pad_oe, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule